// File: doc/BRIEF.md
# Registered Narrow-to-Wide Bus Exchanger

This block moves data between a narrow 12-bit port (A) and a wide port made of two 12-bit halves (1B and 2B), all in step with one clock. Going from A to the wide side, the path toward 1B has two register stages and the path toward 2B has one. With the right clock-enable sequence, two A words that arrive on consecutive cycles therefore appear side by side as one 24-bit word. Going from the wide side to A, each B half is captured in its own register. A registered select then decides which captured half is driven onto A.

Every tri-state port is modelled as a data vector plus a drive flag. An undriven output presents zero data with its flag low. Each input carries a "driven" qualifier. When that qualifier is low, a bus-hold register supplies the last value that was actually driven on that input. The output enables and the select are registered, so a direction change takes effect on the clock edge that samples it and never combinationally. Each clock enable is sampled on the same edge as the data it gates.

Top module: `wide_bus_xchg`

## Requirements
- R1: While `rst_n` is low at a rising edge, every data register, bus-hold register and the select are cleared and both output enables become inactive. After that edge `a_oe`, `b_oe`, `a_out`, `b1_out` and `b2_out` are all 0.
- R2: At a rising edge where `ce_a2b_n` is 0, the 2B register loads the effective A value, and `b2_out` shows it after that edge (when B is driven).
- R3: At a rising edge, the first 1B stage loads the effective A value if `ce_a1_n` is 0. On the same edge the second 1B stage loads the old first-stage value if `ce_a2_n` is 0. `b1_out` shows the second stage.
- R4: Word W0 is applied with only `ce_a1_n` low. On the next edge W1 is applied with `ce_a2_n` and `ce_a2b_n` low. After that second edge, `b1_out` = W0 and `b2_out` = W1 are presented together.
- R5: At a rising edge, the 1B capture register loads the effective `b1_in` if `ce_b1_n` is 0, and the 2B capture register loads the effective `b2_in` if `ce_b2_n` is 0. A shows a captured value one edge after capture.
- R6: When the registered select is 0, A drives the captured 1B value. When it is 1, A drives the captured 2B value. A change of `sel` before edge N changes `a_out` only after edge N.
- R7: The output enables are active low and registered. `oe_a_n` = 0 sampled at edge N makes `a_oe` = 1 after edge N, and likewise `oe_b_n` for `b_oe`. An undriven port shows `*_oe` = 0 and data 0.
- R8: When an input's drive qualifier (`a_in_vld`, `b1_in_vld`, `b2_in_vld`) is 0, the value used is the last one seen at an edge with the qualifier at 1 (0 after reset).
- R9: A register whose clock enable is 1 at an edge keeps its contents, whatever its data input.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Synchronous reset, active low |
| a_in | input | 12 | A-side input data |
| a_in_vld | input | 1 | A input is being driven |
| a_out | output | 12 | A-side output data (0 when undriven) |
| a_oe | output | 1 | A port is driving |
| b1_in | input | 12 | 1B-half input data |
| b1_in_vld | input | 1 | 1B input is being driven |
| b2_in | input | 12 | 2B-half input data |
| b2_in_vld | input | 1 | 2B input is being driven |
| b1_out | output | 12 | 1B-half output data (0 when undriven) |
| b2_out | output | 12 | 2B-half output data (0 when undriven) |
| b_oe | output | 1 | B port is driving |
| ce_a1_n | input | 1 | Load enable, first A-to-1B stage, active low |
| ce_a2_n | input | 1 | Load enable, second A-to-1B stage, active low |
| ce_a2b_n | input | 1 | Load enable, A-to-2B register, active low |
| ce_b1_n | input | 1 | Load enable, 1B capture register, active low |
| ce_b2_n | input | 1 | Load enable, 2B capture register, active low |
| oe_a_n | input | 1 | A output enable, active low, registered |
| oe_b_n | input | 1 | B output enable, active low, registered |
| sel | input | 1 | A source select: 0 = 1B, 1 = 2B; registered |

## Verification
The hardest state to reach from the ports is a clock edge where the first 1B stage loads a new word and the second stage takes the old one, while a bus-hold value is being consumed instead of a live input. That edge must also coincide with an output-enable or select change that may only show one edge later. The stimulus sweeps every combination of the eight control bits and the three drive qualifiers, cycle after cycle, with arithmetic data. This reaches simultaneous loads, holds and enable changes in all their interleavings. Directed sequences then cover the two-word packing, the bus-hold reuse and a reset in the middle of traffic.

// File: rtl/wbx_pkg.sv
// Package: shared types for the bus exchanger.
// Assumes: nothing beyond IEEE 1800-2017.
package wbx_pkg;

    // Source choice for the A port
    typedef enum logic {
        SEL_1B = 1'b0,
        SEL_2B = 1'b1
    } wbx_sel_e;

    // Registered direction controls
    typedef struct packed {
        logic     oe_a_n;
        logic     oe_b_n;
        wbx_sel_e sel;
    } wbx_ctrl_t;

    localparam wbx_ctrl_t CTRL_RESET = '{oe_a_n: 1'b1, oe_b_n: 1'b1, sel: SEL_1B};

endpackage

// File: rtl/wbx_hold.sv
// Module: bus-hold model for one input vector.
// Passes the live value while it is driven. Otherwise it supplies the last
// value seen at a clock edge while driven.
// Assumes: the drive qualifier is synchronous to clk.
module wbx_hold #(
    parameter int W = 12
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] din,
    input  logic         drv,
    output logic [W-1:0] dout
);

    logic [W-1:0] last_q;

    // Remember the most recent driven value
    always_ff @(posedge clk) begin
        if (!rst_n)   last_q <= '0;
        else if (drv) last_q <= din;
    end

    // Live value when driven, held value otherwise
    always_comb begin
        dout = drv ? din : last_q;
    end

endmodule

// File: rtl/wbx_ctrl_regs.sv
// Module: registered output enables and select.
// Direction changes appear only after the edge that samples them.
// Assumes: synchronous active-low reset leaves both ports undriven.
module wbx_ctrl_regs
    import wbx_pkg::*;
(
    input  logic      clk,
    input  logic      rst_n,
    input  wbx_ctrl_t ctrl_d,
    output wbx_ctrl_t ctrl_q
);

    // Capture controls on every edge
    always_ff @(posedge clk) begin
        if (!rst_n) ctrl_q <= CTRL_RESET;
        else        ctrl_q <= ctrl_d;
    end

endmodule

// File: rtl/wbx_a2b_path.sv
// Module: A-to-B staging.
// Two cascaded registers feed 1B and one register feeds 2B, each with its own
// active-low load enable. This lets two consecutive A words line up as one
// wide word.
// Assumes: enables are sampled on the same edge as the data.
module wbx_a2b_path #(
    parameter int W = 12
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] a_eff,
    input  logic         ce_s1_n,
    input  logic         ce_s2_n,
    input  logic         ce_2b_n,
    output logic [W-1:0] b1_word,
    output logic [W-1:0] b2_word
);

    logic [W-1:0] s1_q;
    logic [W-1:0] s2_q;
    logic [W-1:0] r2b_q;

    // First 1B stage: samples A
    always_ff @(posedge clk) begin
        if (!rst_n)        s1_q <= '0;
        else if (!ce_s1_n) s1_q <= a_eff;
    end

    // Second 1B stage: samples the first stage
    always_ff @(posedge clk) begin
        if (!rst_n)        s2_q <= '0;
        else if (!ce_s2_n) s2_q <= s1_q;
    end

    // Single 2B stage: samples A
    always_ff @(posedge clk) begin
        if (!rst_n)        r2b_q <= '0;
        else if (!ce_2b_n) r2b_q <= a_eff;
    end

    // Present stage outputs to the B side
    always_comb begin
        b1_word = s2_q;
        b2_word = r2b_q;
    end

endmodule

// File: rtl/wbx_b2a_path.sv
// Module: B-to-A capture and selection.
// Each B half has its own load-enabled capture register, and the registered
// select picks which one feeds A.
// Assumes: select comes from the control register block.
module wbx_b2a_path
    import wbx_pkg::*;
#(
    parameter int W = 12
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] b1_eff,
    input  logic [W-1:0] b2_eff,
    input  logic         ce_c1_n,
    input  logic         ce_c2_n,
    input  wbx_sel_e     sel_q,
    output logic [W-1:0] a_word
);

    logic [W-1:0] c1_q;
    logic [W-1:0] c2_q;

    // Capture the 1B half
    always_ff @(posedge clk) begin
        if (!rst_n)        c1_q <= '0;
        else if (!ce_c1_n) c1_q <= b1_eff;
    end

    // Capture the 2B half
    always_ff @(posedge clk) begin
        if (!rst_n)        c2_q <= '0;
        else if (!ce_c2_n) c2_q <= b2_eff;
    end

    // Choose the half that feeds A
    always_comb begin
        a_word = (sel_q == SEL_2B) ? c2_q : c1_q;
    end

endmodule

// File: rtl/wide_bus_xchg.sv
// Module: registered narrow-to-wide bus exchanger (top).
// Tri-state ports are modelled as data plus a drive flag, and undriven data
// reads 0. Inputs pass through bus-hold models. Output enables and select are
// registered.
// Assumes: a single clock domain and a synchronous active-low reset.
module wide_bus_xchg
    import wbx_pkg::*;
#(
    parameter int W = 12
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] a_in,
    input  logic         a_in_vld,
    output logic [W-1:0] a_out,
    output logic         a_oe,
    input  logic [W-1:0] b1_in,
    input  logic         b1_in_vld,
    input  logic [W-1:0] b2_in,
    input  logic         b2_in_vld,
    output logic [W-1:0] b1_out,
    output logic [W-1:0] b2_out,
    output logic         b_oe,
    input  logic         ce_a1_n,
    input  logic         ce_a2_n,
    input  logic         ce_a2b_n,
    input  logic         ce_b1_n,
    input  logic         ce_b2_n,
    input  logic         oe_a_n,
    input  logic         oe_b_n,
    input  logic         sel
);

    localparam int NIN = 3;

    logic [W-1:0] raw_in  [NIN];
    logic         raw_drv [NIN];
    logic [W-1:0] eff_in  [NIN];

    wbx_ctrl_t    ctrl_d;
    wbx_ctrl_t    ctrl_q;
    logic [W-1:0] b1_word;
    logic [W-1:0] b2_word;
    logic [W-1:0] a_word;

    // Gather the inputs for the bus-hold array
    always_comb begin
        raw_in[0]  = a_in;
        raw_drv[0] = a_in_vld;
        raw_in[1]  = b1_in;
        raw_drv[1] = b1_in_vld;
        raw_in[2]  = b2_in;
        raw_drv[2] = b2_in_vld;
    end

    for (genvar g = 0; g < NIN; g++) begin : g_hold
        wbx_hold #(.W(W)) u_hold (
            .clk  (clk),
            .rst_n(rst_n),
            .din  (raw_in[g]),
            .drv  (raw_drv[g]),
            .dout (eff_in[g])
        );
    end

    // Pack direction controls
    always_comb begin
        ctrl_d.oe_a_n = oe_a_n;
        ctrl_d.oe_b_n = oe_b_n;
        ctrl_d.sel    = wbx_sel_e'(sel);
    end

    wbx_ctrl_regs u_ctrl (
        .clk   (clk),
        .rst_n (rst_n),
        .ctrl_d(ctrl_d),
        .ctrl_q(ctrl_q)
    );

    wbx_a2b_path #(.W(W)) u_a2b (
        .clk    (clk),
        .rst_n  (rst_n),
        .a_eff  (eff_in[0]),
        .ce_s1_n(ce_a1_n),
        .ce_s2_n(ce_a2_n),
        .ce_2b_n(ce_a2b_n),
        .b1_word(b1_word),
        .b2_word(b2_word)
    );

    wbx_b2a_path #(.W(W)) u_b2a (
        .clk    (clk),
        .rst_n  (rst_n),
        .b1_eff (eff_in[1]),
        .b2_eff (eff_in[2]),
        .ce_c1_n(ce_b1_n),
        .ce_c2_n(ce_b2_n),
        .sel_q  (ctrl_q.sel),
        .a_word (a_word)
    );

    // Drive the port models from the registered enables
    always_comb begin
        a_oe   = !ctrl_q.oe_a_n;
        b_oe   = !ctrl_q.oe_b_n;
        a_out  = a_oe ? a_word  : '0;
        b1_out = b_oe ? b1_word : '0;
        b2_out = b_oe ? b2_word : '0;
    end

endmodule

// File: rtl/wbx_checker.sv
// Module: assertion checker for the exchanger, attached by bind.
// Assumes: observes top-level ports only.
module wbx_checker #(
    parameter int W = 12
) (
    input logic         clk,
    input logic         rst_n,
    input logic [W-1:0] a_in,
    input logic         a_in_vld,
    input logic [W-1:0] a_out,
    input logic         a_oe,
    input logic [W-1:0] b1_in,
    input logic         b1_in_vld,
    input logic [W-1:0] b1_out,
    input logic [W-1:0] b2_out,
    input logic         b_oe,
    input logic         ce_a2_n,
    input logic         ce_a2b_n,
    input logic         ce_b1_n,
    input logic         oe_a_n,
    input logic         oe_b_n,
    input logic         sel
);

    // R2: a driven A word loaded into 2B appears one edge later
    a_r2_b2_load: assert property (@(posedge clk) disable iff (!rst_n)
        (!ce_a2b_n && a_in_vld && !oe_b_n) |=> (b2_out == $past(a_in)));

    // R9: 2B keeps its value while its enable is high and B stays driven
    a_r9_b2_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (ce_a2b_n && b_oe && !oe_b_n) |=> $stable(b2_out));

    // R3: second 1B stage holds while its enable is high
    a_r3_b1_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (ce_a2_n && b_oe && !oe_b_n) |=> $stable(b1_out));

    // R5: 1B capture reaches A one edge later when selected
    a_r5_b1_to_a: assert property (@(posedge clk) disable iff (!rst_n)
        (!ce_b1_n && b1_in_vld && !sel && !oe_a_n) |=> (a_out == $past(b1_in)));

    // R7: registered B enable
    a_r7_oe_b_on: assert property (@(posedge clk) disable iff (!rst_n)
        !oe_b_n |=> b_oe);
    a_r7_oe_b_off: assert property (@(posedge clk) disable iff (!rst_n)
        oe_b_n |=> (!b_oe && b1_out == '0 && b2_out == '0));

    // R7: registered A enable
    a_r7_oe_a_off: assert property (@(posedge clk) disable iff (!rst_n)
        oe_a_n |=> (!a_oe && a_out == '0));

endmodule

bind wide_bus_xchg wbx_checker #(.W(W)) u_wbx_checker (
    .clk      (clk),
    .rst_n    (rst_n),
    .a_in     (a_in),
    .a_in_vld (a_in_vld),
    .a_out    (a_out),
    .a_oe     (a_oe),
    .b1_in    (b1_in),
    .b1_in_vld(b1_in_vld),
    .b1_out   (b1_out),
    .b2_out   (b2_out),
    .b_oe     (b_oe),
    .ce_a2_n  (ce_a2_n),
    .ce_a2b_n (ce_a2b_n),
    .ce_b1_n  (ce_b1_n),
    .oe_a_n   (oe_a_n),
    .oe_b_n   (oe_b_n),
    .sel      (sel)
);

// File: tb/wide_bus_xchg_test.sv
`timescale 1ns/1ps
module wide_bus_xchg_test;

    localparam int W = 12;
    localparam logic [W-1:0] MSK = '1;

    logic         clk = 1'b0;
    logic         rst_n;
    logic [W-1:0] a_in, b1_in, b2_in;
    logic         a_in_vld, b1_in_vld, b2_in_vld;
    logic [W-1:0] a_out, b1_out, b2_out;
    logic         a_oe, b_oe;
    logic         ce_a1_n, ce_a2_n, ce_a2b_n, ce_b1_n, ce_b2_n;
    logic         oe_a_n, oe_b_n, sel;

    int total = 0;
    int bad   = 0;
    bit done  = 1'b0;

    // reference state
    logic [W-1:0] m_s1, m_s2, m_2b, m_c1, m_c2, m_ha, m_hb1, m_hb2;
    logic         m_oea_n, m_oeb_n, m_sel;

    always #2 clk = ~clk;

    wide_bus_xchg #(.W(W)) uut (
        .clk(clk), .rst_n(rst_n),
        .a_in(a_in), .a_in_vld(a_in_vld), .a_out(a_out), .a_oe(a_oe),
        .b1_in(b1_in), .b1_in_vld(b1_in_vld), .b2_in(b2_in), .b2_in_vld(b2_in_vld),
        .b1_out(b1_out), .b2_out(b2_out), .b_oe(b_oe),
        .ce_a1_n(ce_a1_n), .ce_a2_n(ce_a2_n), .ce_a2b_n(ce_a2b_n),
        .ce_b1_n(ce_b1_n), .ce_b2_n(ce_b2_n),
        .oe_a_n(oe_a_n), .oe_b_n(oe_b_n), .sel(sel)
    );

    task automatic chk(string req, string what, logic [W-1:0] act, logic [W-1:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s %s: actual=%h expected=%h", req, what, act, exp);
        end
    endtask

    // advance the reference model one edge from the current inputs
    task automatic model_edge();
        logic [W-1:0] ea, eb1, eb2;
        ea  = a_in_vld  ? a_in  : m_ha;
        eb1 = b1_in_vld ? b1_in : m_hb1;
        eb2 = b2_in_vld ? b2_in : m_hb2;
        if (!rst_n) begin
            {m_s1, m_s2, m_2b, m_c1, m_c2, m_ha, m_hb1, m_hb2} = '0;
            m_oea_n = 1'b1; m_oeb_n = 1'b1; m_sel = 1'b0;
        end else begin
            if (!ce_a2_n)  m_s2 = m_s1;
            if (!ce_a1_n)  m_s1 = ea;
            if (!ce_a2b_n) m_2b = ea;
            if (!ce_b1_n)  m_c1 = eb1;
            if (!ce_b2_n)  m_c2 = eb2;
            m_ha  = ea;  m_hb1 = eb1;  m_hb2 = eb2;
            m_oea_n = oe_a_n; m_oeb_n = oe_b_n; m_sel = sel;
        end
    endtask

    task automatic tick();
        model_edge();
        @(posedge clk);
        #1;
    endtask

    task automatic check_model(string req);
        chk(req, "a_oe",   W'(a_oe), W'(!m_oea_n));
        chk(req, "b_oe",   W'(b_oe), W'(!m_oeb_n));
        chk(req, "a_out",  a_out,  m_oea_n ? '0 : (m_sel ? m_c2 : m_c1));
        chk(req, "b1_out", b1_out, m_oeb_n ? '0 : m_s2);
        chk(req, "b2_out", b2_out, m_oeb_n ? '0 : m_2b);
    endtask

    task automatic idle_ctl();
        ce_a1_n = 1; ce_a2_n = 1; ce_a2b_n = 1; ce_b1_n = 1; ce_b2_n = 1;
    endtask

    task automatic report();
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    endtask

    initial begin
        #800000;
        if (!done) begin
            bad++;
            total++;
            $display("FAIL watchdog: actual=hung expected=finished");
            report();
        end
    end

    initial begin
        rst_n = 0; a_in = 0; b1_in = 0; b2_in = 0;
        a_in_vld = 1; b1_in_vld = 1; b2_in_vld = 1;
        idle_ctl(); oe_a_n = 0; oe_b_n = 0; sel = 0;
        #1;
        tick(); tick();
        // R1: reset state
        chk("R1", "a_oe", W'(a_oe), '0);
        chk("R1", "b_oe", W'(b_oe), '0);
        chk("R1", "a_out", a_out, '0);
        chk("R1", "b1_out", b1_out, '0);
        chk("R1", "b2_out", b2_out, '0);
        rst_n = 1;

        // R4: two-word packing
        a_in = 12'hA5C; ce_a1_n = 0; tick(); check_model("R4");
        a_in = 12'h3E7; ce_a1_n = 1; ce_a2_n = 0; ce_a2b_n = 0; tick();
        chk("R4", "b1_out", b1_out, 12'hA5C);
        chk("R4", "b2_out", b2_out, 12'h3E7);
        idle_ctl();

        // R7: enable latency - change before edge, outputs move after it
        oe_b_n = 1; #1;
        chk("R7", "b_oe before edge", W'(b_oe), W'(1));
        tick();
        chk("R7", "b_oe after edge", W'(b_oe), '0);
        chk("R7", "b1_out undriven", b1_out, '0);
        oe_b_n = 0; tick();
        chk("R7", "b1_out redriven", b1_out, 12'hA5C);

        // R6: select latency
        b1_in = 12'h111; b2_in = 12'h222; ce_b1_n = 0; ce_b2_n = 0; tick();
        idle_ctl(); check_model("R5");
        chk("R6", "a_out sel 1B", a_out, 12'h111);
        sel = 1; #1;
        chk("R6", "a_out before edge", a_out, 12'h111);
        tick();
        chk("R6", "a_out sel 2B", a_out, 12'h222);

        // R8: bus hold supplies the last driven value
        a_in = 12'h6B4; tick();
        a_in_vld = 0; a_in = 12'hFFF; ce_a2b_n = 0; tick();
        chk("R8", "b2_out held A", b2_out, 12'h6B4);
        idle_ctl(); a_in_vld = 1;

        // R2 R3 R5 R9 R6 R7 R8: near-exhaustive control sweep
        for (int i = 0; i < 2048; i++) begin
            {b2_in_vld, b1_in_vld, a_in_vld, sel, oe_b_n, oe_a_n,
             ce_b2_n, ce_b1_n, ce_a2b_n, ce_a2_n, ce_a1_n} = 11'(i ^ (i >> 3));
            a_in  = W'(i * 37 + 5) & MSK;
            b1_in = W'(i * 91 + 13) & MSK;
            b2_in = W'(i * 53 + 700) & MSK;
            tick();
            check_model("R2 R3 R5 R9 sweep");
        end

        // R1: reset in the middle of traffic
        idle_ctl(); rst_n = 0; tick();
        check_model("R1");
        chk("R1", "mid b2_out", b2_out, '0);
        rst_n = 1; oe_a_n = 0; oe_b_n = 0; tick();
        chk("R1", "cleared a_out", a_out, '0);
        chk("R1", "cleared b1_out", b1_out, '0);

        done = 1;
        report();
    end

endmodule